// File: doc/BRIEF.md
# Address-Filtered Dual-Buffer Frame Receiver

This block takes received Ethernet frames from a byte-wide stream with a valid strobe and an end-of-frame marker. It checks the destination address of each frame against a programmed station address and writes each frame it keeps into one of two receive buffers. When a frame has been stored completely, the block marks that buffer as full in the buffer's control word. Software then owns that buffer until it writes the full flag back to zero.

A frame is dropped in two cases: the selected buffer is still owned by software, or the frame is too long to fit. Each such drop increments a counter. A frame that fails the address filter is discarded without being counted. When alternation is enabled, the receiver moves to the other buffer after every stored frame. A one-cycle interrupt pulse can announce each stored frame. It is gated per buffer and by a global enable.

Software reads and writes through a word-wide port with a 12-bit byte address. Address bit 11 selects the buffer. The last word of each 2 KiB half is that buffer's control word. Every other word in the half is frame data and can only be read.

Top module: `pprx_rx_filter`

## Requirements
- R1: A frame whose first destination byte has bit 7 set (0x80) is stored without any address compare, whatever its length.
- R2: Any other frame is stored only if its first six bytes equal `station_addr`, with byte k taken from bits 8k+7..8k. A frame that does not match changes neither the full flag nor the drop counter, and raises no interrupt.
- R3: If the full flag of the selected buffer is set when the first byte arrives, a frame that passes the filter is dropped. The drop counter increments, and the buffer's contents and flags stay unchanged.
- R4: A frame that passes the filter with a length of 2020 bytes or more is dropped and counted. A 2019-byte frame is stored completely.
- R5: Byte n of a stored frame sits in data word n/4 at bit lane 8*(n mod 4). Bank 0 is at 0x000 and bank 1 at 0x800. The control words are at 0x7FC and 0xFFC, with bit 0 as the full flag and bit 3 as the interrupt enable. `cpu_rdata` shows the word addressed in the previous cycle.
- R6: `irq_pulse` is high for exactly the one cycle after the last byte of a stored frame. It fires only when that buffer's interrupt enable and `irq_gie` are both set.
- R7: Reset selects buffer 0. After each stored frame the selection flips when `alt_en` is high and stays unchanged when it is low. Dropped and filtered frames never move it.
- R8: A write to a control word loads both the full flag and the interrupt enable. Writing the full flag as zero returns the buffer to the receiver for its next frame.
- R9: The drop counter increments by exactly one for each dropped frame, in the cycle after that frame's last byte. It never changes at any other time.
- R10: The address filter is applied before the busy check. A non-matching frame that arrives while the selected buffer is full is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_en | input | 1 | Alternate buffers after each stored frame |
| irq_gie | input | 1 | Global interrupt enable |
| station_addr | input | 48 | Station address, first wire byte in bits 7..0 |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| cpu_addr | input | 12 | Software byte address (bit 11 selects bank) |
| cpu_wr | input | 1 | Software write strobe (control words only) |
| cpu_wdata | input | 32 | Software write data |
| cpu_rdata | output | 32 | Read data, one cycle after address |
| irq_pulse | output | 1 | One-cycle frame-stored interrupt |
| active_buf | output | 1 | Buffer that will receive the next frame |
| drop_count | output | 16 | Count of busy and oversize drops |

## Verification
The assertions expect `in_last` to appear only together with `in_valid`. They also expect each frame to end before the next one starts. The interrupt and drop-counter properties are tied to a registered end-of-frame beat and depend on this. The stimulus sends whole frames as contiguous beats and leaves an idle cycle after each one. It changes `alt_en` and `irq_gie` only between frames, so a stored frame never sees a mode that differs from the one the bench expects.

// File: rtl/pprx_pkg.sv
package pprx_pkg;

    // Per-buffer control word: bit 3 interrupt enable, bit 0 full flag.
    typedef struct packed {
        logic irq_en;
        logic full;
    } buf_ctrl_t;

    localparam int unsigned DEST_BYTES   = 6;
    localparam int unsigned CTRL_FULL_BIT = 0;
    localparam int unsigned CTRL_IRQ_BIT  = 3;

endpackage

// File: rtl/pprx_dest_filter.sv
module pprx_dest_filter #(
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [47:0]      station,
    output logic             keep
);
    import pprx_pkg::*;

    typedef struct packed {
        logic grp;
        logic eq;
    } flt_t;

    flt_t f_q, f_d;
    logic grp_now, eq_now, byte_ok, six_seen, in_dest;

    always_comb begin
        in_dest  = idx < LEN_W'(DEST_BYTES);
        byte_ok  = in_dest ? (data == station[8*idx[2:0] +: 8]) : 1'b1;
        grp_now  = (idx == '0) ? data[7] : f_q.grp;
        eq_now   = ((idx == '0) ? 1'b1 : f_q.eq) & byte_ok;
        six_seen = idx >= LEN_W'(DEST_BYTES - 1);
        keep     = grp_now | (eq_now & six_seen);
        f_d      = f_q;
        if (beat) begin
            f_d.grp = grp_now;
            f_d.eq  = eq_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/pprx_frame_buf.sv
module pprx_frame_buf #(
    parameter int unsigned WORDS = 505,
    parameter int unsigned WAW   = 9
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic           wr_bank,
    input  logic [WAW-1:0] wr_word,
    input  logic [1:0]     wr_lane,
    input  logic [7:0]     wr_byte,
    input  logic           rd_bank,
    input  logic [WAW-1:0] rd_word,
    output logic [31:0]    rd_data
);
    logic [31:0] bank_rd [2];
    logic [31:0] rd_d, rd_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [31:0] mem_q [WORDS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)) && (wr_word < WAW'(WORDS)))
                mem_q[wr_word][8*wr_lane +: 8] <= wr_byte;
        end
        always_comb begin
            bank_rd[b] = (rd_word < WAW'(WORDS)) ? mem_q[rd_word] : '0;
        end
    end

    always_comb rd_d = bank_rd[rd_bank];

    always_ff @(posedge clk) rd_q <= rd_d;

    assign rd_data = rd_q;
endmodule

// File: rtl/pprx_rx_filter.sv
module pprx_rx_filter #(
    parameter int unsigned MAX_LEN    = 2020,
    parameter int unsigned BANK_BYTES = 2048,
    parameter int unsigned DROP_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alt_en,
    input  logic                            irq_gie,
    input  logic [47:0]                     station_addr,
    input  logic                            in_valid,
    input  logic [7:0]                      in_data,
    input  logic                            in_last,
    input  logic [$clog2(BANK_BYTES):0]     cpu_addr,
    input  logic                            cpu_wr,
    input  logic [31:0]                     cpu_wdata,
    output logic [31:0]                     cpu_rdata,
    output logic                            irq_pulse,
    output logic                            active_buf,
    output logic [DROP_W-1:0]               drop_count
);
    import pprx_pkg::*;

    localparam int unsigned OFF_W = $clog2(BANK_BYTES);
    localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);
    localparam int unsigned CAP   = MAX_LEN - 1;
    localparam int unsigned WORDS = (CAP + 3) / 4;
    localparam int unsigned WAW   = OFF_W - 2;

    typedef struct packed {
        logic [LEN_W-1:0]  cnt;
        logic              busy;
        logic              cur;
        buf_ctrl_t [1:0]   ctrl;
        logic [DROP_W-1:0] drops;
        logic              irq;
        logic              rd_ctrl;
        buf_ctrl_t         rctrl;
    } state_t;

    state_t s_q, s_d;

    logic      keep, busy_now, over, wr_en, done, commit, lost;
    logic      cpu_bank, cpu_is_ctrl;
    buf_ctrl_t cur_ctrl;
    logic [31:0] mem_rdata;

    pprx_dest_filter #(.LEN_W(LEN_W)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (in_valid),
        .idx     (s_q.cnt),
        .data    (in_data),
        .station (station_addr),
        .keep    (keep)
    );

    pprx_frame_buf #(.WORDS(WORDS), .WAW(WAW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (s_q.cur),
        .wr_word (WAW'(s_q.cnt >> 2)),
        .wr_lane (s_q.cnt[1:0]),
        .wr_byte (in_data),
        .rd_bank (cpu_bank),
        .rd_word (cpu_addr[OFF_W-1:2]),
        .rd_data (mem_rdata)
    );

    always_comb begin
        cpu_bank    = cpu_addr[OFF_W];
        cpu_is_ctrl = &cpu_addr[OFF_W-1:2];
        cur_ctrl    = s_q.ctrl[s_q.cur];
        busy_now    = (s_q.cnt == '0) ? cur_ctrl.full : s_q.busy;
        over        = s_q.cnt >= LEN_W'(CAP);
        wr_en       = in_valid && !busy_now && (s_q.cnt < LEN_W'(CAP));
        done        = in_valid && in_last;
        commit      = done && keep && !busy_now && !over;
        lost        = done && keep && (busy_now || over);

        s_d         = s_q;
        s_d.irq     = 1'b0;
        s_d.rd_ctrl = cpu_is_ctrl;
        s_d.rctrl   = s_q.ctrl[cpu_bank];

        if (cpu_wr && cpu_is_ctrl) begin
            s_d.ctrl[cpu_bank].irq_en = cpu_wdata[CTRL_IRQ_BIT];
            s_d.ctrl[cpu_bank].full   = cpu_wdata[CTRL_FULL_BIT];
        end

        if (in_valid) begin
            s_d.busy = busy_now;
            if (in_last)                       s_d.cnt = '0;
            else if (s_q.cnt != LEN_W'(MAX_LEN)) s_d.cnt = s_q.cnt + 1'b1;
        end

        if (commit) begin
            s_d.ctrl[s_q.cur].full = 1'b1;
            s_d.irq                = cur_ctrl.irq_en & irq_gie;
            s_d.cur                = s_q.cur ^ alt_en;
        end

        if (lost) s_d.drops = s_q.drops + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cpu_rdata = mem_rdata;
        if (s_q.rd_ctrl) begin
            cpu_rdata = '0;
            cpu_rdata[CTRL_IRQ_BIT]  = s_q.rctrl.irq_en;
            cpu_rdata[CTRL_FULL_BIT] = s_q.rctrl.full;
        end
    end

    assign irq_pulse  = s_q.irq;
    assign active_buf = s_q.cur;
    assign drop_count = s_q.drops;
endmodule

// File: rtl/pprx_rx_filter_chk.sv
module pprx_rx_filter_chk #(
    parameter int unsigned DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic              alt_en,
    input logic              irq_gie,
    input logic              irq_pulse,
    input logic              active_buf,
    input logic [DROP_W-1:0] drop_count
);
    // R6: a pulse follows an end-of-frame beat
    a_r6_irq_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(in_valid && in_last));

    // R6: a pulse needs the global enable
    a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(irq_gie));

    // R7: selection moves only after a frame end with alternation on
    a_r7_flip_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (active_buf != $past(active_buf)) |-> $past(in_valid && in_last && alt_en));

    // R9: counter steps by one, only after a frame end
    a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
            ((drop_count == $past(drop_count) + 1'b1) && $past(in_valid && in_last)));
endmodule

bind pprx_rx_filter pprx_rx_filter_chk #(.DROP_W(DROP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .alt_en     (alt_en),
    .irq_gie    (irq_gie),
    .irq_pulse  (irq_pulse),
    .active_buf (active_buf),
    .drop_count (drop_count)
);

// File: tb/pprx_rx_filter_tb.sv
module pprx_rx_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_en = 1'b1;
    logic        irq_gie = 1'b1;
    logic [47:0] station_addr = 48'h5A_44_33_22_11_02;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq_pulse;
    logic        active_buf;
    logic [15:0] drop_count;

    int tests = 0;
    int fails = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    pprx_rx_filter u_dut (
        .clk(clk), .rst_n(rst_n), .alt_en(alt_en), .irq_gie(irq_gie),
        .station_addr(station_addr), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_pulse(irq_pulse),
        .active_buf(active_buf), .drop_count(drop_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each interrupt pulse must match an expected item (R6)
    always @(negedge clk) begin
        if (rst_n && irq_pulse) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6 unexpected irq actual=1 expected=0");
            end else begin
                void'(exp_q.pop_front());
            end
        end
    end

    function automatic logic [7:0] fbyte(input logic [47:0] dest, input int seed, input int i);
        return (i < 6) ? dest[8*i +: 8] : 8'((seed + i) & 8'hFF);
    endfunction

    function automatic logic [31:0] fword(input logic [47:0] dest, input int seed, input int w);
        return {fbyte(dest, seed, 4*w+3), fbyte(dest, seed, 4*w+2),
                fbyte(dest, seed, 4*w+1), fbyte(dest, seed, 4*w)};
    endfunction

    task automatic send(input logic [47:0] dest, input int len, input int seed, input bit want_irq);
        if (want_irq) exp_q.push_back(seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbyte(dest, seed, i);
            in_last  = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 irq queue drained", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_addr = a;
        @(negedge clk);
        d = cpu_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [47:0] miss;
        logic [47:0] grp;
        logic [31:0] keep0;
        miss = station_addr ^ 48'h01_00_00_00_00_00;
        grp  = 48'hAB_CD_EF_01_02_81;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset selects buffer 0", 32'(active_buf), 0);
        chk("R9 reset drop count", 32'(drop_count), 0);
        chk("R6 reset irq low", 32'(irq_pulse), 0);
        rd(12'h7FC, d); chk("R5 reset ctrl0", d, 0);

        wr(12'h7FC, 32'h8);
        wr(12'hFFC, 32'h8);
        rd(12'hFFC, d); chk("R8 ctrl1 load irq_en", d, 32'h8);

        // R2 matching unicast frame into bank 0
        send(station_addr, 10, 16, 1'b1);
        rd(12'h7FC, d); chk("R2 match sets full", d, 32'h9);
        rd(12'h000, d); chk("R5 word0 layout", d, fword(station_addr, 16, 0));
        keep0 = d;
        rd(12'h004, d); chk("R5 word1 layout", d, fword(station_addr, 16, 1));
        chk("R7 flip after store", 32'(active_buf), 1);

        // R2 mismatching frame is silent
        send(miss, 12, 40, 1'b0);
        rd(12'hFFC, d); chk("R2 mismatch leaves ctrl1", d, 32'h8);
        chk("R2 mismatch not counted", 32'(drop_count), 0);
        chk("R7 no flip on filtered frame", 32'(active_buf), 1);

        // R1 group frame, short length
        send(grp, 3, 60, 1'b1);
        rd(12'hFFC, d); chk("R1 group short frame stored", d, 32'h9);
        rd(12'h800, d);
        chk("R1 group data low bytes", d & 32'h00FFFFFF, fword(grp, 60, 0) & 32'h00FFFFFF);
        chk("R7 flip back", 32'(active_buf), 0);

        // R3 both buffers full: matching frame lost
        send(station_addr, 9, 80, 1'b0);
        chk("R3 busy drop counted", 32'(drop_count), 1);
        rd(12'h7FC, d); chk("R3 busy ctrl0 unchanged", d, 32'h9);
        rd(12'h000, d); chk("R3 busy buffer untouched", d, keep0);
        chk("R7 no flip on drop", 32'(active_buf), 0);

        // R10 mismatch while busy not counted
        send(miss, 9, 90, 1'b0);
        chk("R10 filter before busy", 32'(drop_count), 1);

        // R8 release and R4 oversize
        wr(12'h7FC, 32'h8);
        rd(12'h7FC, d); chk("R8 release clears full", d, 32'h8);
        send(grp, 2020, 3, 1'b0);
        chk("R4 oversize counted", 32'(drop_count), 2);
        rd(12'h7FC, d); chk("R4 oversize leaves ctrl0", d, 32'h8);

        // R4 largest accepted frame
        send(grp, 2019, 5, 1'b1);
        rd(12'h7FC, d); chk("R4 2019 bytes stored", d, 32'h9);
        rd(12'h7E0, d);
        chk("R4 last word", d & 32'h00FFFFFF, fword(grp, 5, 504) & 32'h00FFFFFF);
        chk("R7 flip to 1", 32'(active_buf), 1);

        // R6 per-buffer enable off
        wr(12'hFFC, 32'h0);
        send(station_addr, 8, 7, 1'b0);
        rd(12'hFFC, d); chk("R6 stored without irq", d, 32'h1);

        // R6 global enable off
        wr(12'h7FC, 32'h8);
        irq_gie = 1'b0;
        send(station_addr, 8, 9, 1'b0);
        rd(12'h7FC, d); chk("R6 gie off still stores", d, 32'h9);
        irq_gie = 1'b1;
        chk("R7 at bank1", 32'(active_buf), 1);

        // R7 alternation disabled
        alt_en = 1'b0;
        wr(12'hFFC, 32'h0);
        send(station_addr, 8, 11, 1'b0);
        chk("R7 no flip when disabled", 32'(active_buf), 1);
        rd(12'hFFC, d); chk("R7 same buffer reused", d, 32'h1);
        wr(12'hFFC, 32'h8);
        send(grp, 6, 13, 1'b1);
        chk("R7 still bank1", 32'(active_buf), 1);
        rd(12'h800, d); chk("R8 reuse after release", d, fword(grp, 13, 0));
        chk("R9 final drop count", 32'(drop_count), 2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule